// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Nibble Addressing

This block is the bus-facing half of a small two-wire slave peripheral. It oversamples the serial clock and data lines with a fast system clock and recognizes start and stop conditions. It frames the serial stream into bytes and checks the first byte after every start against a device address. It drives the acknowledge bits and exchanges bytes with a command engine that sits behind it. The data line is open drain, so the block only ever pulls it low through `sda_drive_low`. The block never holds the clock low.

The address byte carries no direction bit. Its upper nibble is a fixed device type code (binary 0101). Its lower nibble must equal a 4-bit strap input. A `busy` input from the command engine, high while a slow internal write runs, keeps the slave from acknowledging its address. A master can therefore poll with start-plus-address until it gets an acknowledge. Bytes after the address go to the engine as single-cycle `rx_valid` pulses with a position index (0 for the command byte, counting up and saturating). The engine decides through `ack_enable` whether a data byte is acknowledged. To send a byte back, the engine offers `tx_data` with `tx_valid` while `tx_ready` is high. `tx_ready` is open only during the acknowledge pulse of a received byte, and the transfer happens on a cycle where both are high. There is no other back-pressure: a byte not offered in that window means the next byte slot is received from the master. `bus_end` pulses once when a transaction that won an address acknowledge ends, either by a stop or by a repeated start.

Top module: `tw_slave`

## Requirements
- R1: After reset, `sda_drive_low`, `rx_valid`, `tx_ready` and `bus_end` are all low, and the slave ignores the bus until a start condition (SDA falling while SCL is high) is seen.
- R2: A first byte after a start whose bits 7..4 are 0101 and whose bits 3..0 equal `strap_addr` is acknowledged by pulling SDA low during the 9th SCL pulse while `busy` is low.
- R3: A first byte whose type nibble or strap nibble differs is not acknowledged, and all later bytes up to the next start produce no `rx_valid` and no acknowledge.
- R4: While `busy` is high at the end of the address byte, the address is not acknowledged. The same address is acknowledged once `busy` is low.
- R5: The byte after an acknowledged address (the command byte) is always acknowledged and is reported with one `rx_valid` pulse, `rx_data` MSB first as sent, and `rx_index` 0.
- R6: Each later received byte is reported with `rx_index` counting up from 1. It is acknowledged only if `ack_enable` is high at its 8th SCL falling edge. `tx_ready` is high only while the slave drives an acknowledge.
- R7: A byte taken through the `tx_valid`/`tx_ready` handshake is sent in the next byte slot, MSB first, each bit launched after SCL falls and held stable while SCL is high. SDA is released for the master's acknowledge bit.
- R8: A start condition in the middle of a byte restarts framing, so the next 8 bits are treated as an address byte.
- R9: `bus_end` pulses for one cycle on a stop, or on a repeated start, that ends a transaction whose address was acknowledged. It does not pulse otherwise.
- R10: While idle (before any start, or after a stop), the slave never drives SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (wired level) |
| sda_drive_low | output | 1 | High pulls the open-drain data line low |
| strap_addr | input | 4 | Pin-strapped low nibble of the device address |
| busy | input | 1 | Command engine busy; suppresses address acknowledge |
| ack_enable | input | 1 | Acknowledge data bytes with index 1 and above |
| rx_valid | output | 1 | One-cycle pulse: a received byte is on rx_data |
| rx_data | output | 8 | Received byte |
| rx_index | output | 2 | Position of the byte after the address, saturating |
| tx_valid | input | 1 | Engine offers a byte to transmit |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Slave can take a transmit byte this cycle |
| bus_end | output | 1 | One-cycle pulse at the end of an addressed transaction |

## Verification
Framing that slips by a bit appears at the ports within one byte time. The acknowledge lands on the wrong SCL pulse, or `rx_data` comes out shifted. A decode that runs from a stale state instead of the start condition shows as an acknowledge to a foreign or busy address, or as a missing one, at the 9th pulse of the address byte. A broken transmit path appears as the wrong bits on SDA during SCL-high windows. A lost engaged flag appears as a missing or extra `bus_end` pulse at the stop or repeated start that closes the transfer.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] TYPE_CODE = 4'b0101;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_TXA, S_SKIP
  } tw_state_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      q_d  <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], d};
      q_d  <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~q_d;
  assign fall = ~q & q_d;
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              busy,
  input  logic              ack_enable,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_drive_low,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_index,
  output logic              tx_ready,
  output logic              bus_end,
  output tw_state_t         state_o,
  output logic              is_addr_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  tw_state_t         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shift;
  logic [BYTE_W-1:0] tx_sh;
  logic [IDX_W-1:0]  idx;
  logic              is_addr, engaged, ack_high, tx_loaded, m_ack;
  logic              ack_ok;
  logic [IDX_W-1:0]  idx_next;

  always_comb begin
    if (is_addr)
      ack_ok = (shift[BYTE_W-1 -: 4] == TYPE_CODE) &&
               (shift[ADDR_W-1:0] == strap_addr) && !busy;
    else
      ack_ok = (idx == '0) || ack_enable;
    idx_next = (idx == IDX_MAX) ? idx : idx + 1'b1;
  end

  assign tx_ready = (state == S_ACK) && ack_high && !tx_loaded && !scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      bitcnt        <= '0;
      shift         <= '0;
      tx_sh         <= '0;
      idx           <= '0;
      is_addr       <= 1'b0;
      engaged       <= 1'b0;
      ack_high      <= 1'b0;
      tx_loaded     <= 1'b0;
      m_ack         <= 1'b0;
      sda_drive_low <= 1'b0;
      rx_valid      <= 1'b0;
      bus_end       <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      bus_end  <= 1'b0;
      if (tx_ready && tx_valid) begin
        tx_sh     <= tx_data;
        tx_loaded <= 1'b1;
      end
      if (start_ev) begin
        bus_end       <= engaged;
        engaged       <= 1'b0;
        state         <= S_RX;
        bitcnt        <= '0;
        is_addr       <= 1'b1;
        idx           <= '0;
        sda_drive_low <= 1'b0;
        tx_loaded     <= 1'b0;
        ack_high      <= 1'b0;
      end else if (stop_ev) begin
        bus_end       <= engaged;
        engaged       <= 1'b0;
        state         <= S_IDLE;
        sda_drive_low <= 1'b0;
        tx_loaded     <= 1'b0;
      end else begin
        unique case (state)
          S_RX: begin
            if (scl_rise) begin
              shift  <= {shift[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT && !is_addr) rx_valid <= 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              if (ack_ok) begin
                state         <= S_ACK;
                sda_drive_low <= 1'b1;
                ack_high      <= 1'b0;
                if (is_addr) engaged <= 1'b1;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_ACK: begin
            if (scl_rise) begin
              ack_high <= 1'b1;
            end else if (scl_fall) begin
              bitcnt   <= '0;
              ack_high <= 1'b0;
              is_addr  <= 1'b0;
              if (!is_addr) idx <= idx_next;
              if (tx_loaded) begin
                state         <= S_TX;
                sda_drive_low <= ~tx_sh[BYTE_W-1];
                tx_loaded     <= 1'b0;
              end else begin
                state         <= S_RX;
                sda_drive_low <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_drive_low <= 1'b0;
                state         <= S_TXA;
              end else begin
                tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_drive_low <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          S_TXA: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (m_ack) begin
                state <= S_RX;
                idx   <= idx_next;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_data   = shift;
  assign rx_index  = idx;
  assign state_o   = state;
  assign is_addr_o = is_addr;
endmodule

// File: rtl/tw_slave.sv
module tw_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int IDX_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              busy,
  input  logic              ack_enable,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic [IDX_W-1:0]  rx_index,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              bus_end
);
  logic      scl_s, scl_rise, scl_fall;
  logic      sda_s, sda_rise, sda_fall;
  logic      start_ev, stop_ev;
  tw_state_t state;
  logic      is_addr;

  tw_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .rise(scl_rise), .fall(scl_fall)
  );
  tw_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_ev = sda_fall && scl_s;
  assign stop_ev  = sda_rise && scl_s;

  tw_frame #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .strap_addr(strap_addr), .busy(busy), .ack_enable(ack_enable),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .sda_drive_low(sda_drive_low), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_index(rx_index), .tx_ready(tx_ready), .bus_end(bus_end),
    .state_o(state), .is_addr_o(is_addr)
  );
endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk
  import tw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_s,
  input logic      start_ev,
  input logic      stop_ev,
  input logic      sda_drive_low,
  input logic      busy,
  input logic      rx_valid,
  input logic      tx_ready,
  input logic      bus_end,
  input tw_state_t state,
  input logic      is_addr
);
  p_drive_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_drive_low))
    else $error("drive changed while SCL high");

  p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_low) && is_addr) |-> !$past(busy))
    else $error("address acknowledged while busy");

  p_ready_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sda_drive_low)
    else $error("tx_ready outside acknowledge");

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("rx_valid longer than one cycle");

  p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_end |=> !bus_end)
    else $error("bus_end longer than one cycle");

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_drive_low)
    else $error("drive low while idle");
endmodule

bind tw_slave tw_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_drive_low(sda_drive_low), .busy(busy), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .bus_end(bus_end), .state(state), .is_addr(is_addr)
);

// File: tb/sim_tw_slave.sv
`timescale 1ns/1ps
module sim_tw_slave;
  localparam int H = 10;
  localparam logic [3:0] STRAP = 4'hA;
  localparam logic [7:0] MY_ADDR = {4'b0101, STRAP};

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_drive_low, busy = 0, ack_enable = 0;
  logic rx_valid, tx_valid = 0, tx_ready, bus_end;
  logic [7:0] rx_data, tx_data = 0;
  logic [1:0] rx_index;
  logic [3:0] strap = STRAP;
  wire  sda_line = m_sda & ~sda_drive_low;

  int total = 0, bad = 0;
  int rx_cnt = 0, end_cnt = 0;
  logic [7:0] last_rx;
  logic [1:0] last_idx;

  always #10 clk = ~clk;

  tw_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .strap_addr(strap), .busy(busy),
    .ack_enable(ack_enable), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_index(rx_index), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .bus_end(bus_end)
  );

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt++; last_rx = rx_data; last_idx = rx_index; end
    if (bus_end) end_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; wait_h(H); m_scl = 1; wait_h(H);
    m_sda = 0; wait_h(H); m_scl = 0; wait_h(H);
  endtask

  task automatic bus_stop;
    m_sda = 0; wait_h(H); m_scl = 1; wait_h(H);
    m_sda = 1; wait_h(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wait_h(H); m_scl = 1; wait_h(H); m_scl = 0; wait_h(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1; wait_h(H); m_scl = 1; wait_h(H/2);
    b = sda_line; wait_h(H/2); m_scl = 0; wait_h(2);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic m_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!m_ack);
  endtask

  task automatic t_reset;
    check("R1 drive", sda_drive_low, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 tx_ready", tx_ready, 0);
    check("R1 bus_end", bus_end, 0);
  endtask

  task automatic t_no_start;
    logic a;
    int rc = rx_cnt;
    put_byte(MY_ADDR, a);
    check("R10 no ack before start", a, 0);
    put_byte(8'h90, a);
    check("R10 no rx before start", rx_cnt - rc, 0);
  endtask

  task automatic t_addr_ok;
    logic a;
    int ec = end_cnt;
    bus_start; put_byte(MY_ADDR, a);
    check("R2 address ack", a, 1);
    bus_stop;
    check("R9 bus_end on stop", end_cnt - ec, 1);
    check("R10 idle released", sda_drive_low, 0);
  endtask

  task automatic t_addr_bad;
    logic a;
    int rc = rx_cnt, ec = end_cnt;
    bus_start; put_byte(8'h4A, a);
    check("R3 type mismatch nack", a, 0);
    put_byte(8'h90, a);
    check("R3 later byte nack", a, 0);
    check("R3 later byte no rx", rx_cnt - rc, 0);
    bus_start; put_byte(8'h5B, a);
    check("R3 strap mismatch nack", a, 0);
    bus_stop;
    check("R9 no bus_end unaddressed", end_cnt - ec, 0);
  endtask

  task automatic t_busy;
    logic a;
    busy = 1;
    bus_start; put_byte(MY_ADDR, a);
    check("R4 busy nack", a, 0);
    bus_stop;
    busy = 0;
    bus_start; put_byte(MY_ADDR, a);
    check("R4 ack after busy", a, 1);
    bus_stop;
  endtask

  task automatic t_write;
    logic a;
    int rc = rx_cnt;
    bus_start; put_byte(MY_ADDR, a);
    ack_enable = 0;
    put_byte(8'hA3, a);
    check("R5 command ack", a, 1);
    check("R5 command data", last_rx, 8'hA3);
    check("R5 command index", last_idx, 0);
    ack_enable = 1;
    put_byte(8'h2B, a);
    check("R6 data ack", a, 1);
    check("R6 data value", last_rx, 8'h2B);
    check("R6 data index", last_idx, 1);
    ack_enable = 0;
    put_byte(8'h77, a);
    check("R6 data nack", a, 0);
    check("R6 rx count", rx_cnt - rc, 3);
    bus_stop;
  endtask

  task automatic t_read;
    logic a;
    logic [7:0] v;
    int ec = end_cnt;
    bus_start; put_byte(MY_ADDR, a);
    tx_data = 8'hC3; tx_valid = 1;
    put_byte(8'h9F, a);
    tx_valid = 0;
    check("R7 command ack", a, 1);
    get_byte(v, 0);
    check("R7 tx byte", v, 8'hC3);
    bus_stop;
    check("R9 bus_end after read", end_cnt - ec, 1);
  endtask

  task automatic t_restart;
    logic a;
    int ec = end_cnt;
    bus_start; put_byte(MY_ADDR, a);
    put_bit(1); put_bit(0); put_bit(1);
    bus_start;
    check("R9 bus_end on restart", end_cnt - ec, 1);
    put_byte(MY_ADDR, a);
    check("R8 address after restart", a, 1);
    put_byte(8'h5A, a);
    check("R8 framing reset data", last_rx, 8'h5A);
    check("R8 framing reset index", last_idx, 0);
    bus_stop;
  endtask

  initial begin
    wait_h(5); rst_n = 1; wait_h(5);
    t_reset;
    t_no_start;
    t_addr_ok;
    t_addr_bad;
    t_busy;
    t_write;
    t_read;
    t_restart;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule